// File: doc/BRIEF.md
# Fault-Aware Surrounding XY Route Selector

This block chooses the output port for a packet head arriving at one router of a two-dimensional mesh. It compares the packet's destination coordinates with the router's own coordinates and picks one of five ports: local, east, west, north or south. Four status inputs report which neighbours are out of service. With every neighbour alive the choice follows dimension-ordered routing, X first and then Y. When the port that plain routing would use leads to a dead router, the packet steps sideways in the other dimension so that it can pass around the dead router.

Routers on the boundary of the mesh treat the absent neighbour beyond the edge as dead. The mesh size is a parameter. Column 0 is the west edge and row 0 is the north (top) edge. When every allowed escape is closed, the block raises an unroutable flag and requests no port at all. A decision is taken for each head flit presented with `head_valid`. It is registered, and a one-cycle `route_valid` strobe marks it. The registered result then holds until the next head flit arrives.

Top module: `surr_xy_route`

## Requirements
- R1: When the destination coordinates equal the router's own coordinates, the result is the local port: `route_dir` = 5'b00001.
- R2: The port encoding is one-hot, with bit 0 = local, bit 1 = east (x+1), bit 2 = west (x-1), bit 3 = north (y-1) and bit 4 = south (y+1). With no port blocked, east is chosen when dest_x > own_x and west when dest_x < own_x. When X already matches, south is chosen when dest_y > own_y and north when dest_y < own_y.
- R3: If X differs and the needed horizontal port is blocked, the block takes a vertical step instead. It first tries the vertical port toward dest_y: south if dest_y > own_y, otherwise north, including when Y already matches. If that port is also blocked, it tries the opposite vertical port.
- R4: If X matches, Y differs and the needed vertical port is blocked, the block takes a horizontal step: east unless east is blocked, otherwise west.
- R5: A port counts as blocked when its dead input is high or when the router sits on that edge of the mesh. The edges are own_x = 0 for west, own_x = COLS-1 for east, own_y = 0 for north and own_y = ROWS-1 for south. A blocked port is never chosen.
- R6: If the preferred port and both detour candidates are blocked, `unroutable` is 1 and `route_dir` is all zeros.
- R7: A head flit sampled with `head_valid` high produces `route_valid` = 1 for exactly the next cycle. `route_dir` and `unroutable` keep their values while no head flit is sampled.
- R8: While reset is asserted, `route_valid`, `route_dir` and `unroutable` are all zero.
- R9: At most one bit of `route_dir` is ever set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| head_valid | input | 1 | A head flit is present and needs a decision |
| dest_x | input | XW | Destination column |
| dest_y | input | YW | Destination row |
| own_x | input | XW | Column of this router |
| own_y | input | YW | Row of this router |
| dead_e | input | 1 | East neighbour is out of service |
| dead_w | input | 1 | West neighbour is out of service |
| dead_n | input | 1 | North neighbour is out of service |
| dead_s | input | 1 | South neighbour is out of service |
| route_valid | output | 1 | One-cycle strobe: a new decision is present |
| route_dir | output | 5 | One-hot chosen port (bit 0 local, 1 E, 2 W, 3 N, 4 S) |
| unroutable | output | 1 | Every allowed escape was blocked |

## Verification
The block keeps almost no state, so a wrong decision shows on `route_dir` and `unroutable` in the cycle right after the head flit. A fault in the capture register shows in two ways. The result would fail to hold through idle cycles, or the strobe would appear in the wrong cycle. The sweep covers every own position, every destination and every dead-neighbour pattern on a 3x3 mesh, so every edge and corner detour is reached. Idle gaps placed between heads, with the inputs changed, expose a capture that is not gated by `head_valid`.

// File: rtl/surr_xy_pkg.sv
package surr_xy_pkg;
   // Bit positions of the one-hot port vector; the neighbour decodes them.
   localparam int unsigned PORT_LOCAL = 0;
   localparam int unsigned PORT_EAST  = 1;
   localparam int unsigned PORT_WEST  = 2;
   localparam int unsigned PORT_NORTH = 3;
   localparam int unsigned PORT_SOUTH = 4;
   localparam int unsigned NUM_PORTS  = 5;

   typedef logic [NUM_PORTS-1:0] port_vec_t;
endpackage

// File: rtl/surr_xy_block_mask.sv
// Merges neighbour-dead flags with mesh-edge detection into one blocked mask.
module surr_xy_block_mask
   import surr_xy_pkg::*;
#(
   parameter int unsigned MESH_COLS = 4,
   parameter int unsigned MESH_ROWS = 4,
   parameter int unsigned XW        = 2,
   parameter int unsigned YW        = 2
) (
   input  logic [XW-1:0] own_x,
   input  logic [YW-1:0] own_y,
   input  logic          dead_e,
   input  logic          dead_w,
   input  logic          dead_n,
   input  logic          dead_s,
   output port_vec_t     blocked
);
   localparam logic [XW-1:0] X_LAST = XW'(MESH_COLS - 1);
   localparam logic [YW-1:0] Y_LAST = YW'(MESH_ROWS - 1);

   assign blocked[PORT_LOCAL] = 1'b0;

   for (genvar g = 1; g < NUM_PORTS; g++) begin : g_side
      logic at_edge;
      logic dead_flag;
      if (g == PORT_EAST) begin : g_e
         assign at_edge   = (own_x == X_LAST);
         assign dead_flag = dead_e;
      end else if (g == PORT_WEST) begin : g_w
         assign at_edge   = (own_x == '0);
         assign dead_flag = dead_w;
      end else if (g == PORT_NORTH) begin : g_n
         assign at_edge   = (own_y == '0);
         assign dead_flag = dead_n;
      end else begin : g_s
         assign at_edge   = (own_y == Y_LAST);
         assign dead_flag = dead_s;
      end
      assign blocked[g] = at_edge | dead_flag;
   end
endmodule

// File: rtl/surr_xy_decide.sv
// Combinational port choice: X-first, with cross-dimension detours.
module surr_xy_decide
   import surr_xy_pkg::*;
#(
   parameter int unsigned XW = 2,
   parameter int unsigned YW = 2
) (
   input  logic [XW-1:0] own_x,
   input  logic [YW-1:0] own_y,
   input  logic [XW-1:0] dest_x,
   input  logic [YW-1:0] dest_y,
   input  port_vec_t     blocked,
   output port_vec_t     dir_oh,
   output logic          unroutable
);
   logic       x_eq, y_eq, x_gt, y_gt;
   logic [2:0] pick_h, first_v, second_v;

   assign x_eq = (dest_x == own_x);
   assign y_eq = (dest_y == own_y);
   assign x_gt = (dest_x > own_x);
   assign y_gt = (dest_y > own_y);

   assign pick_h   = x_gt ? 3'(PORT_EAST)  : 3'(PORT_WEST);
   assign first_v  = y_gt ? 3'(PORT_SOUTH) : 3'(PORT_NORTH);
   assign second_v = y_gt ? 3'(PORT_NORTH) : 3'(PORT_SOUTH);

   always_comb begin
      dir_oh     = '0;
      unroutable = 1'b0;
      if (x_eq && y_eq) begin
         dir_oh[PORT_LOCAL] = 1'b1;
      end else if (!x_eq) begin
         if (!blocked[pick_h])        dir_oh[pick_h]   = 1'b1;
         else if (!blocked[first_v])  dir_oh[first_v]  = 1'b1;
         else if (!blocked[second_v]) dir_oh[second_v] = 1'b1;
         else                         unroutable       = 1'b1;
      end else begin
         if (!blocked[first_v])         dir_oh[first_v]   = 1'b1;
         else if (!blocked[PORT_EAST])  dir_oh[PORT_EAST] = 1'b1;
         else if (!blocked[PORT_WEST])  dir_oh[PORT_WEST] = 1'b1;
         else                           unroutable        = 1'b1;
      end
   end
endmodule

// File: rtl/surr_xy_result_reg.sv
// Captures a decision on each head flit and emits a one-cycle strobe.
module surr_xy_result_reg #(
   parameter int unsigned DW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [DW-1:0] d_dir,
   input  logic          d_unr,
   output logic          q_valid,
   output logic [DW-1:0] q_dir,
   output logic          q_unr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_valid <= 1'b0;
         q_dir   <= '0;
         q_unr   <= 1'b0;
      end else begin
         q_valid <= load;
         if (load) begin
            q_dir <= d_dir;
            q_unr <= d_unr;
         end
      end
   end
endmodule

// File: rtl/surr_xy_route.sv
module surr_xy_route
   import surr_xy_pkg::*;
#(
   parameter int unsigned MESH_COLS = 4,
   parameter int unsigned MESH_ROWS = 4,
   localparam int unsigned XW = (MESH_COLS > 1) ? $clog2(MESH_COLS) : 1,
   localparam int unsigned YW = (MESH_ROWS > 1) ? $clog2(MESH_ROWS) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          head_valid,
   input  logic [XW-1:0] dest_x,
   input  logic [YW-1:0] dest_y,
   input  logic [XW-1:0] own_x,
   input  logic [YW-1:0] own_y,
   input  logic          dead_e,
   input  logic          dead_w,
   input  logic          dead_n,
   input  logic          dead_s,
   output logic          route_valid,
   output logic [4:0]    route_dir,
   output logic          unroutable
);
   if (MESH_COLS < 2 || MESH_ROWS < 2) begin : g_bad_dims
      $error("surr_xy_route: mesh needs at least 2 columns and 2 rows");
   end

   port_vec_t blocked;
   port_vec_t next_dir;
   logic      next_unr;

   surr_xy_block_mask #(
      .MESH_COLS(MESH_COLS), .MESH_ROWS(MESH_ROWS), .XW(XW), .YW(YW)
   ) i_mask (
      .own_x(own_x), .own_y(own_y),
      .dead_e(dead_e), .dead_w(dead_w), .dead_n(dead_n), .dead_s(dead_s),
      .blocked(blocked)
   );

   surr_xy_decide #(.XW(XW), .YW(YW)) i_decide (
      .own_x(own_x), .own_y(own_y), .dest_x(dest_x), .dest_y(dest_y),
      .blocked(blocked), .dir_oh(next_dir), .unroutable(next_unr)
   );

   surr_xy_result_reg #(.DW(NUM_PORTS)) i_result (
      .clk(clk), .rst_n(rst_n), .load(head_valid),
      .d_dir(next_dir), .d_unr(next_unr),
      .q_valid(route_valid), .q_dir(route_dir), .q_unr(unroutable)
   );
endmodule

// File: rtl/surr_xy_route_chk.sv
module surr_xy_route_chk #(
   parameter int unsigned MESH_COLS = 4,
   parameter int unsigned MESH_ROWS = 4,
   parameter int unsigned XW = 2,
   parameter int unsigned YW = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          head_valid,
   input logic [XW-1:0] dest_x,
   input logic [YW-1:0] dest_y,
   input logic [XW-1:0] own_x,
   input logic [YW-1:0] own_y,
   input logic          dead_e,
   input logic          dead_w,
   input logic          dead_n,
   input logic          dead_s,
   input logic          route_valid,
   input logic [4:0]    route_dir,
   input logic          unroutable
);
   // R7
   strobe_follows_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
      head_valid |=> route_valid);
   // R7
   strobe_needs_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
      route_valid |-> $past(head_valid));
   // R7
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(head_valid) |-> ($stable(route_dir) && $stable(unroutable)));
   // R9
   dir_onehot0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(route_dir));
   // R6
   unroutable_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unroutable |-> (route_dir == 5'b0));
   // R1
   local_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (route_valid && route_dir[0]) |-> $past(dest_x == own_x && dest_y == own_y));
   // R5
   east_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (route_valid && route_dir[1]) |-> $past(!dead_e && own_x != XW'(MESH_COLS-1)));
   // R5
   north_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (route_valid && route_dir[3]) |-> $past(!dead_n && own_y != '0));
endmodule

bind surr_xy_route surr_xy_route_chk #(
   .MESH_COLS(MESH_COLS), .MESH_ROWS(MESH_ROWS), .XW(XW), .YW(YW)
) i_chk (
   .clk(clk), .rst_n(rst_n), .head_valid(head_valid),
   .dest_x(dest_x), .dest_y(dest_y), .own_x(own_x), .own_y(own_y),
   .dead_e(dead_e), .dead_w(dead_w), .dead_n(dead_n), .dead_s(dead_s),
   .route_valid(route_valid), .route_dir(route_dir), .unroutable(unroutable)
);

// File: tb/test_surr_xy_route.sv
module test_surr_xy_route;
   localparam int C = 3;
   localparam int R = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       head_valid = 1'b0;
   logic [1:0] dest_x = '0, dest_y = '0, own_x = '0, own_y = '0;
   logic       dead_e = 1'b0, dead_w = 1'b0, dead_n = 1'b0, dead_s = 1'b0;
   logic       route_valid;
   logic [4:0] route_dir;
   logic       unroutable;

   int compared = 0;
   int mismatched = 0;
   bit done = 0;

   always #2 clk = ~clk;

   surr_xy_route #(.MESH_COLS(C), .MESH_ROWS(R)) i_surr_xy_route (
      .clk(clk), .rst_n(rst_n), .head_valid(head_valid),
      .dest_x(dest_x), .dest_y(dest_y), .own_x(own_x), .own_y(own_y),
      .dead_e(dead_e), .dead_w(dead_w), .dead_n(dead_n), .dead_s(dead_s),
      .route_valid(route_valid), .route_dir(route_dir), .unroutable(unroutable)
   );

   // Expected {unroutable, dir} and the rule that decided it.
   function automatic logic [5:0] expect_route(int ox, int oy, int dx, int dy,
                                               logic [3:0] dd, output string tag);
      logic be, bw, bn, bs;
      be = dd[0] || ox == C-1;
      bw = dd[1] || ox == 0;
      bn = dd[2] || oy == 0;
      bs = dd[3] || oy == R-1;
      if (dx == ox && dy == oy) begin tag = "R1"; return 6'b000001; end
      if (dx != ox) begin
         if (dx > ox && !be) begin tag = "R2"; return 6'b000010; end
         if (dx < ox && !bw) begin tag = "R2"; return 6'b000100; end
         tag = "R3";
         if (dy > oy) begin
            if (!bs) return 6'b010000;
            if (!bn) return 6'b001000;
         end else begin
            if (!bn) return 6'b001000;
            if (!bs) return 6'b010000;
         end
         tag = "R6";
         return 6'b100000;
      end
      if (dy > oy && !bs) begin tag = "R2"; return 6'b010000; end
      if (dy < oy && !bn) begin tag = "R2"; return 6'b001000; end
      tag = "R4";
      if (!be) return 6'b000010;
      if (!bw) return 6'b000100;
      tag = "R6";
      return 6'b100000;
   endfunction

   task automatic check(string tag, logic [6:0] act, logic [6:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s act={vld,unr,dir}=%b exp=%b", tag, act, exp);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         mismatched++;
         $display("FAIL watchdog expired");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      int n = 0;
      logic [5:0] exp;
      logic [5:0] last;
      string tag;
      repeat (3) @(negedge clk);
      // R8 reset state
      check("R8", {route_valid, unroutable, route_dir}, 7'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R8", {route_valid, unroutable, route_dir}, 7'b0);
      for (int ox = 0; ox < C; ox++)
         for (int oy = 0; oy < R; oy++)
            for (int dx = 0; dx < C; dx++)
               for (int dy = 0; dy < R; dy++)
                  for (int d = 0; d < 16; d++) begin
                     own_x = 2'(ox); own_y = 2'(oy); dest_x = 2'(dx); dest_y = 2'(dy);
                     {dead_s, dead_n, dead_w, dead_e} = 4'(d);
                     head_valid = 1'b1;
                     exp = expect_route(ox, oy, dx, dy, 4'(d), tag);
                     @(negedge clk);
                     // R9 one-hot result, R5 edge blocking folded into model
                     check(tag, {route_valid, unroutable, route_dir}, {1'b1, exp});
                     last = exp;
                     n++;
                     if (n % 7 == 0) begin
                        // R7 idle: strobe drops, result held despite new inputs
                        head_valid = 1'b0;
                        dest_x = own_x; dest_y = own_y;
                        {dead_s, dead_n, dead_w, dead_e} = ~4'(d);
                        @(negedge clk);
                        check("R7", {route_valid, unroutable, route_dir}, {1'b0, last});
                     end
                  end
      head_valid = 1'b0;
      @(negedge clk);
      check("R7", {route_valid, unroutable, route_dir}, {1'b0, last});
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule